// File: doc/BRIEF.md
# Lane-Parallel Fixed-Point Multiply-Accumulate Unit

This unit performs fixed-point arithmetic on a 32-bit packed operand word that is split at run time into four 8-bit lanes, two 16-bit lanes or one 32-bit lane. Each request names one of three operations: multiply only, accumulate only (the lane of operand A is added to the lane's running sum), or multiply-accumulate. The same request also says whether lanes carry real or complex values, whether they are integers or binary fractions, and whether they are signed or unsigned. Every lane keeps a private accumulator that is wider than the product, so a long sum can build up before it is read. The result of each accepted request returns as a saturated packed word.

Each lane width has its own bank of accumulators. A request at one width never disturbs the sums held at another width, except through the clear control, which empties every bank. In complex mode, neighbouring lanes are paired. The lower lane of a pair carries the real part and the upper lane carries the imaginary part. The pair then forms a full complex product.

The unit is a fixed two-stage pipeline and accepts one request per clock. Reset is asynchronous and active low. Its release is synchronised inside the block, so requests are taken from the third rising edge after `rst_n` goes high.

Top module: `mac_lanes`

## Requirements
- R1: `in_width` selects the lane layout: 2'b00 gives four 8-bit lanes, 2'b01 gives two 16-bit lanes, and 2'b10 gives one 32-bit lane. Lane i occupies bits [i*W+W-1 : i*W] of operands and result. 2'b11 is illegal.
- R2: `in_op` selects the operation: 2'b00 loads each accumulator with its lane product, 2'b01 adds the lane of `in_a` to the accumulator, and 2'b10 adds the lane product to the accumulator. The result word shows the updated accumulators. 2'b11 is illegal.
- R3: With `in_cplx`=1, lanes 2k (real part) and 2k+1 (imaginary part) form a pair. The product term of lane 2k is ar*br - ai*bi, and that of lane 2k+1 is ar*bi + ai*br.
- R4: With `in_sgn`=1, lanes are two's complement and each output lane saturates to [-2^(W-1), 2^(W-1)-1]. With `in_sgn`=0, lanes are unsigned and each output lane saturates to [0, 2^W-1], reading the accumulator as two's complement.
- R5: With `in_frac`=1, the output lane is the accumulator shifted right arithmetically by W, then saturated. Accumulate-only then adds the A lane shifted left by W. When `in_sgn` is also 1, every elementary product is doubled, and (-2^(W-1))*(-2^(W-1)) gives 2^(2W-1)-1.
- R6: Each accumulator is 2W+8 bits and wraps modulo 2^(2W+8). The banks for 8, 16 and 32 bits keep their values independently.
- R7: `in_clr`=1 with an accepted legal request zeroes every accumulator of every width. The accepted operation then starts from zero.
- R8: A request with an illegal width, an illegal operation, or complex mode at 32-bit width returns `out_err`=1 and `out_data`=0. It changes no accumulator, and its clear is ignored.
- R9: `out_valid` rises exactly two clocks after the `in_valid` it answers, and requests may be given every cycle. `out_data` and `out_err` hold their value while `out_valid` is low.
- R10: Reset clears `out_valid`, `out_err`, `out_data` and every accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_clr | input | 1 | Zero all accumulators before this request |
| in_width | input | 2 | Lane width code |
| in_op | input | 2 | Operation code |
| in_cplx | input | 1 | Complex lane pairs |
| in_frac | input | 1 | Fractional format |
| in_sgn | input | 1 | Signed arithmetic |
| in_a | input | 32 | Packed operand A |
| in_b | input | 32 | Packed operand B |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Request was illegal |
| out_data | output | 32 | Packed saturated result |

## Verification
A wrong accumulator value stays hidden until a multiply-accumulate or accumulate-only request reads that lane. It then shows in `out_data` two clocks after that request. The bench keeps its own per-width accumulator model and compares every cycle. It also drives a long run at one width, and then a request at another width, so that a wrap, a cross-bank disturbance or a missed clear appears within a few cycles. A stage-timing fault shows at once as an `out_valid` mismatch.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_ACC = 2'b01,
    OP_MAC = 2'b10,
    OP_RSV = 2'b11
  } mac_op_e;

  typedef enum logic [1:0] {
    LW_8   = 2'b00,
    LW_16  = 2'b01,
    LW_32  = 2'b10,
    LW_RSV = 2'b11
  } lane_w_e;

  typedef struct packed {
    logic    clr;
    lane_w_e width;
    mac_op_e op;
    logic    cplx;
    logic    frac;
    logic    sgn;
  } mac_ctl_t;

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;

endmodule

// File: rtl/mac_prod.sv
// One elementary lane product with sign, fraction doubling and the
// single saturating corner of signed fractional multiply.
module mac_prod #(
  parameter int W = 8
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  logic                  sgn,
  input  logic                  frac,
  output logic signed [2*W:0]   p
);

  localparam int PW = 2 * W + 1;

  logic signed [W:0]    ea;
  logic signed [W:0]    eb;
  logic signed [PW-1:0] full;
  logic                 both_min;

  always_comb begin
    ea       = {sgn & a[W-1], a};
    eb       = {sgn & b[W-1], b};
    full     = PW'(ea) * PW'(eb);
    both_min = sgn && (a == {1'b1, {(W-1){1'b0}}}) && (b == {1'b1, {(W-1){1'b0}}});
    if (sgn && frac) begin
      if (both_min) p = {2'b00, {(PW-2){1'b1}}};
      else          p = {full[2*W-1:0], 1'b0};
    end else begin
      p = full;
    end
  end

endmodule

// File: rtl/mac_bank.sv
// Accumulator bank for one lane width: products, complex pairing,
// next-state update and saturated view of the updated sums.
module mac_bank
  import mac_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int W       = 8,
  parameter int GUARD   = 8,
  parameter bit CPLX_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr_all,
  input  mac_op_e           op,
  input  logic              cplx,
  input  logic              frac,
  input  logic              sgn,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] q
);

  localparam int N  = WORD_W / W;
  localparam int AW = 2 * W + GUARD;
  localparam int PW = 2 * W + 1;
  localparam logic signed [AW-1:0] ONE  = 1;
  localparam logic signed [AW-1:0] SMAX = (ONE <<< (W - 1)) - ONE;
  localparam logic signed [AW-1:0] SMIN = -(ONE <<< (W - 1));
  localparam logic signed [AW-1:0] UMAX = (ONE <<< W) - ONE;

  function automatic logic signed [AW-1:0] sx(input logic signed [PW-1:0] v);
    return AW'(v);
  endfunction

  logic [W-1:0]          al     [N];
  logic [W-1:0]          bl     [N];
  logic signed [PW-1:0]  pd     [N];
  logic signed [AW-1:0]  term   [N];
  logic signed [AW-1:0]  addend [N];
  logic signed [AW-1:0]  base   [N];
  logic signed [AW-1:0]  acc_d  [N];
  logic signed [AW-1:0]  acc_q  [N];
  logic signed [AW-1:0]  view   [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign al[i] = a[i*W +: W];
    assign bl[i] = b[i*W +: W];
    mac_prod #(.W(W)) u_pd (
      .a(al[i]), .b(bl[i]), .sgn(sgn), .frac(frac), .p(pd[i])
    );
  end

  if (CPLX_OK) begin : g_cx
    logic signed [PW-1:0] px [N];
    for (genvar i = 0; i < N; i++) begin : g_x
      mac_prod #(.W(W)) u_px (
        .a(al[i]), .b(bl[i ^ 1]), .sgn(sgn), .frac(frac), .p(px[i])
      );
      if (i % 2 == 0) begin : g_re
        assign term[i] = cplx ? (sx(pd[i]) - sx(pd[i+1])) : sx(pd[i]);
      end else begin : g_im
        assign term[i] = cplx ? (sx(px[i]) + sx(px[i-1])) : sx(pd[i]);
      end
    end
  end else begin : g_rl
    logic cplx_unused;
    assign cplx_unused = cplx;
    for (genvar i = 0; i < N; i++) begin : g_r
      assign term[i] = sx(pd[i]);
    end
  end

  // next state
  always_comb begin
    for (int k = 0; k < N; k++) begin
      base[k]   = clr_all ? '0 : acc_q[k];
      addend[k] = sgn ? AW'(signed'(al[k])) : AW'(al[k]);
      if (frac) addend[k] = addend[k] <<< W;
      acc_d[k]  = acc_q[k];
      if (en) begin
        case (op)
          OP_MUL:  acc_d[k] = term[k];
          OP_ACC:  acc_d[k] = base[k] + addend[k];
          OP_MAC:  acc_d[k] = base[k] + term[k];
          default: acc_d[k] = acc_q[k];
        endcase
      end else if (clr_all) begin
        acc_d[k] = '0;
      end
    end
  end

  // saturated view of the updated sums
  always_comb begin
    q = '0;
    for (int k = 0; k < N; k++) begin
      view[k] = frac ? (acc_d[k] >>> W) : acc_d[k];
      if (sgn) begin
        if (view[k] > SMAX)      q[k*W +: W] = SMAX[W-1:0];
        else if (view[k] < SMIN) q[k*W +: W] = SMIN[W-1:0];
        else                     q[k*W +: W] = view[k][W-1:0];
      end else begin
        if (view[k] < 0)         q[k*W +: W] = '0;
        else if (view[k] > UMAX) q[k*W +: W] = UMAX[W-1:0];
        else                     q[k*W +: W] = view[k][W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) acc_q[k] <= '0;
    end else if (en || clr_all) begin
      for (int k = 0; k < N; k++) acc_q[k] <= acc_d[k];
    end
  end

endmodule

// File: rtl/mac_lanes.sv
module mac_lanes
  import mac_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int GUARD  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_clr,
  input  logic [1:0]        in_width,
  input  logic [1:0]        in_op,
  input  logic              in_cplx,
  input  logic              in_frac,
  input  logic              in_sgn,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  output logic              out_err,
  output logic [WORD_W-1:0] out_data
);

  localparam int NB     = 3;
  localparam bit CX32OK = (32 < WORD_W);

  logic rst_n_i;

  mac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  // stage 1: request capture
  logic              s1_vld_d, s1_vld_q;
  mac_ctl_t          s1_ctl_d, s1_ctl_q;
  logic [WORD_W-1:0] s1_a_d, s1_a_q, s1_b_d, s1_b_q;

  always_comb begin
    s1_vld_d = in_valid;
    s1_ctl_d = s1_ctl_q;
    s1_a_d   = s1_a_q;
    s1_b_d   = s1_b_q;
    if (in_valid) begin
      s1_ctl_d = '{clr: in_clr, width: lane_w_e'(in_width), op: mac_op_e'(in_op),
                   cplx: in_cplx, frac: in_frac, sgn: in_sgn};
      s1_a_d   = in_a;
      s1_b_d   = in_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s1_vld_q <= 1'b0;
      s1_ctl_q <= '0;
      s1_a_q   <= '0;
      s1_b_q   <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_ctl_q <= s1_ctl_d;
      s1_a_q   <= s1_a_d;
      s1_b_q   <= s1_b_d;
    end
  end

  // stage 2: legality, banks, result select
  logic              bad;
  logic              clr_all;
  logic [WORD_W-1:0] bank_q [NB];
  logic [WORD_W-1:0] pick;

  always_comb begin
    bad = (s1_ctl_q.width == LW_RSV) || (s1_ctl_q.op == OP_RSV) ||
          (s1_ctl_q.cplx && (s1_ctl_q.width == LW_32) && !CX32OK);
    clr_all = s1_vld_q && !bad && s1_ctl_q.clr;
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    localparam int LW = 8 << g;
    logic en;
    assign en = s1_vld_q && !bad && (s1_ctl_q.width == lane_w_e'(g));
    mac_bank #(
      .WORD_W (WORD_W),
      .W      (LW),
      .GUARD  (GUARD),
      .CPLX_OK(LW < WORD_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n_i),
      .en     (en),
      .clr_all(clr_all),
      .op     (s1_ctl_q.op),
      .cplx   (s1_ctl_q.cplx),
      .frac   (s1_ctl_q.frac),
      .sgn    (s1_ctl_q.sgn),
      .a      (s1_a_q),
      .b      (s1_b_q),
      .q      (bank_q[g])
    );
  end

  always_comb begin
    case (s1_ctl_q.width)
      LW_8:    pick = bank_q[0];
      LW_16:   pick = bank_q[1];
      LW_32:   pick = bank_q[2];
      default: pick = '0;
    endcase
  end

  logic              o_vld_d, o_vld_q, o_err_d, o_err_q;
  logic [WORD_W-1:0] o_dat_d, o_dat_q;

  always_comb begin
    o_vld_d = s1_vld_q;
    o_err_d = o_err_q;
    o_dat_d = o_dat_q;
    if (s1_vld_q) begin
      o_err_d = bad;
      o_dat_d = bad ? '0 : pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      o_vld_q <= 1'b0;
      o_err_q <= 1'b0;
      o_dat_q <= '0;
    end else begin
      o_vld_q <= o_vld_d;
      o_err_q <= o_err_d;
      o_dat_q <= o_dat_d;
    end
  end

  assign out_valid = o_vld_q;
  assign out_err   = o_err_q;
  assign out_data  = o_dat_q;

endmodule

// File: rtl/mac_lanes_chk.sv
module mac_lanes_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_width,
  input logic [1:0]        in_op,
  input logic              in_cplx,
  input logic              out_valid,
  input logic              out_err,
  input logic [WORD_W-1:0] out_data
);

  // cycles since reset release, saturating
  logic [2:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen <= '0;
    else if (seen != 3'd7) seen <= seen + 3'd1;
  end

  // R9: result strobe lags request strobe by two clocks
  a_r9_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd4) |-> (out_valid == $past(in_valid, 2)));

  // R9: outputs hold between results
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd1 && !out_valid) |-> ($stable(out_data) && $stable(out_err)));

  // R8: a flagged result carries a zero word
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == '0));

  // R8: complex at the widest lane is refused
  a_r8_cplx32: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd2 && in_valid && in_cplx && in_width == 2'b10) |-> ##2 (out_valid && out_err));

  // R1 / R2: reserved codes are refused
  a_r1_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd2 && in_valid && (in_width == 2'b11 || in_op == 2'b11)) |-> ##2 (out_valid && out_err));

endmodule

bind mac_lanes mac_lanes_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/mac_lanes_test.sv
`timescale 1ns/1ps
module mac_lanes_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_clr, in_cplx, in_frac, in_sgn;
  logic [1:0]  in_width, in_op;
  logic [31:0] in_a, in_b;
  logic        out_valid, out_err;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  mac_lanes uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clr(in_clr),
    .in_width(in_width), .in_op(in_op), .in_cplx(in_cplx), .in_frac(in_frac),
    .in_sgn(in_sgn), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_err(out_err), .out_data(out_data)
  );

  int n_vec = 0;
  int n_bad = 0;

  // behavioural model state
  logic signed [71:0] macc [3][4];
  logic        p_v [2];
  logic        p_e [2];
  logic [31:0] p_q [2];
  string       p_t [2];
  logic [31:0] hold_q;
  logic        hold_e;

  function automatic logic signed [71:0] lane(input logic [31:0] x, input int i,
                                              input int w, input logic sg);
    logic [63:0] raw;
    logic signed [71:0] r;
    raw = ({32'd0, x} >> (i * w)) & ((64'd1 << w) - 64'd1);
    r = $signed({8'd0, raw});
    if (sg && raw[w-1]) r = r - (72'sd1 <<< w);
    return r;
  endfunction

  function automatic logic signed [71:0] pr(input logic signed [71:0] x, y,
                                            input int w, input logic sg, fr);
    logic signed [71:0] mn, r;
    mn = -(72'sd1 <<< (w - 1));
    if (sg && fr && x == mn && y == mn) return (72'sd1 <<< (2 * w - 1)) - 72'sd1;
    r = x * y;
    if (sg && fr) r = r <<< 1;
    return r;
  endfunction

  function automatic logic signed [71:0] wrap(input logic signed [71:0] v, input int aw);
    logic signed [71:0] t;
    t = v <<< (72 - aw);
    return t >>> (72 - aw);
  endfunction

  task automatic model(input logic clr, input logic [1:0] wc, op, input logic cx, fr, sg,
                       input logic [31:0] a, b, output logic er, output logic [31:0] q);
    int w, n, aw;
    logic signed [71:0] av [4], bv [4], tm, nw, vw, hi, lo;
    q = '0;
    er = (wc == 2'b11) || (op == 2'b11) || (cx && wc == 2'b10);
    if (er) return;
    if (clr) for (int g = 0; g < 3; g++) for (int k = 0; k < 4; k++) macc[g][k] = '0;
    w = 8 << wc; n = 32 / w; aw = 2 * w + 8;
    for (int i = 0; i < n; i++) begin
      av[i] = lane(a, i, w, sg);
      bv[i] = lane(b, i, w, sg);
    end
    for (int i = 0; i < n; i++) begin
      if (!cx)        tm = pr(av[i], bv[i], w, sg, fr);
      else if (i % 2 == 0) tm = pr(av[i], bv[i], w, sg, fr) - pr(av[i+1], bv[i+1], w, sg, fr);
      else            tm = pr(av[i-1], bv[i], w, sg, fr) + pr(av[i], bv[i-1], w, sg, fr);
      case (op)
        2'b00:   nw = tm;
        2'b01:   nw = macc[wc][i] + (fr ? (av[i] <<< w) : av[i]);
        default: nw = macc[wc][i] + tm;
      endcase
      nw = wrap(nw, aw);
      macc[wc][i] = nw;
      vw = fr ? (nw >>> w) : nw;
      if (sg) begin hi = (72'sd1 <<< (w - 1)) - 72'sd1; lo = -(72'sd1 <<< (w - 1)); end
      else    begin hi = (72'sd1 <<< w) - 72'sd1;       lo = 72'sd0; end
      if (vw > hi) vw = hi;
      if (vw < lo) vw = lo;
      q = q | ((32'(vw) & 32'((64'd1 << w) - 64'd1)) << (i * w));
    end
  endtask

  task automatic check_out();
    logic ev, ee;
    logic [31:0] eq;
    string t;
    ev = p_v[1];
    ee = ev ? p_e[1] : hold_e;
    eq = ev ? p_q[1] : hold_q;
    t  = ev ? p_t[1] : "R9";
    n_vec++;
    if (out_valid !== ev || out_err !== ee || out_data !== eq) begin
      n_bad++;
      $display("FAIL %s: valid %b exp %b, err %b exp %b, data %h exp %h",
               t, out_valid, ev, out_err, ee, out_data, eq);
    end
    hold_e = ee;
    hold_q = eq;
  endtask

  task automatic step(input string tag, input logic v, clr, input logic [1:0] wc, op,
                      input logic cx, fr, sg, input logic [31:0] a, b);
    logic e;
    logic [31:0] q;
    @(negedge clk);
    check_out();
    e = 1'b0; q = '0;
    if (v) model(clr, wc, op, cx, fr, sg, a, b, e, q);
    p_v[1] = p_v[0]; p_e[1] = p_e[0]; p_q[1] = p_q[0]; p_t[1] = p_t[0];
    p_v[0] = v;      p_e[0] = e;      p_q[0] = q;      p_t[0] = tag;
    in_valid = v; in_clr = clr; in_width = wc; in_op = op;
    in_cplx = cx; in_frac = fr; in_sgn = sg; in_a = a; in_b = b;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 2'b00, 2'b00, 0, 0, 0, '0, '0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R9: watchdog got no end, expected finish");
    finish_run();
  end

  initial begin
    for (int g = 0; g < 3; g++) for (int k = 0; k < 4; k++) macc[g][k] = '0;
    for (int i = 0; i < 2; i++) begin p_v[i] = 0; p_e[i] = 0; p_q[i] = '0; p_t[i] = "R10"; end
    hold_q = '0; hold_e = 1'b0;
    rst_n = 1'b0;
    in_valid = 0; in_clr = 0; in_width = 0; in_op = 0;
    in_cplx = 0; in_frac = 0; in_sgn = 0; in_a = '0; in_b = '0;
    idle("R10", 3);                       // R10: outputs quiet in reset
    rst_n = 1'b1;
    idle("R10", 4);

    // R10: accumulators start at zero; R1/R2: 8-bit signed integer
    step("R10", 1, 0, 2'b00, 2'b10, 0, 0, 1, 32'h05_FD_02_03, 32'h04_06_F9_07);
    step("R2",  1, 0, 2'b00, 2'b00, 0, 0, 1, 32'h7F_80_10_FF, 32'h02_02_10_FF);
    step("R2",  1, 0, 2'b00, 2'b01, 0, 0, 1, 32'h01_02_03_04, 32'h0);
    step("R2",  1, 0, 2'b00, 2'b10, 0, 0, 1, 32'h01_01_01_01, 32'h01_01_01_01);
    // R1: 16-bit and 32-bit layouts, back to back
    step("R1",  1, 0, 2'b01, 2'b00, 0, 0, 1, 32'h0123_FFFE, 32'h0002_0003);
    step("R1",  1, 0, 2'b10, 2'b10, 0, 0, 1, 32'h0001_0000, 32'h0000_0003);
    step("R1",  1, 0, 2'b10, 2'b01, 0, 0, 0, 32'hFFFF_FFFF, 32'h0);
    // R4: unsigned saturation and negative clamp
    step("R4",  1, 0, 2'b00, 2'b00, 0, 0, 0, 32'hFF_10_02_00, 32'hFF_10_03_05);
    step("R4",  1, 0, 2'b00, 2'b00, 0, 0, 1, 32'h80_7F_40_C0, 32'h7F_7F_02_40);
    // R3: complex pairs at 8 and 16 bits
    step("R3",  1, 1, 2'b00, 2'b00, 1, 0, 1, 32'h04_03_02_01, 32'h02_05_FF_03);
    step("R3",  1, 0, 2'b01, 2'b10, 1, 0, 1, 32'h0003_0002, 32'h0005_0004);
    step("R3",  1, 0, 2'b01, 2'b10, 1, 0, 0, 32'h0001_0001, 32'h0002_0007);
    // R5: signed fraction, most-negative squared and half times half
    step("R5",  1, 0, 2'b00, 2'b00, 0, 1, 1, 32'h80_40_C0_80, 32'h80_40_40_7F);
    step("R5",  1, 0, 2'b01, 2'b00, 0, 1, 1, 32'h8000_4000, 32'h8000_C000);
    step("R5",  1, 0, 2'b00, 2'b01, 0, 1, 1, 32'h10_20_F0_01, 32'h0);
    step("R5",  1, 0, 2'b00, 2'b10, 0, 1, 0, 32'h80_FF_10_01, 32'h80_FF_10_01);
    // R8: illegal requests, clear ignored, then read back unchanged sums
    step("R8",  1, 1, 2'b10, 2'b10, 1, 0, 1, 32'h1, 32'h1);
    step("R8",  1, 1, 2'b11, 2'b00, 0, 0, 1, 32'h1, 32'h1);
    step("R8",  1, 1, 2'b00, 2'b11, 0, 0, 1, 32'h1, 32'h1);
    step("R8",  1, 0, 2'b00, 2'b01, 0, 1, 1, 32'h0, 32'h0);
    idle("R9", 3);
    // R7: clear wipes every bank; the accepted op starts from zero
    step("R7",  1, 0, 2'b01, 2'b01, 0, 0, 1, 32'h0100_0200, 32'h0);
    step("R7",  1, 1, 2'b00, 2'b10, 0, 0, 1, 32'h02_02_02_02, 32'h03_03_03_03);
    step("R7",  1, 0, 2'b01, 2'b01, 0, 0, 1, 32'h0, 32'h0);
    step("R7",  1, 0, 2'b10, 2'b01, 0, 0, 1, 32'h0, 32'h0);
    // R6: guard wrap in the 8-bit bank, 16-bit bank untouched
    step("R6",  1, 0, 2'b01, 2'b01, 0, 0, 1, 32'h0011_0022, 32'h0);
    for (int i = 0; i < 600; i++)
      step("R6", 1, 0, 2'b00, 2'b10, 0, 0, 1, 32'h7F7F7F7F, 32'h7F7F7F7F);
    step("R6",  1, 0, 2'b01, 2'b01, 0, 0, 1, 32'h0, 32'h0);
    // R9: gaps and bursts with random legal and illegal requests
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] wc, op;
      wc = (($urandom % 16) == 0) ? 2'b11 : 2'($urandom % 3);
      op = (($urandom % 16) == 0) ? 2'b11 : 2'($urandom % 3);
      step("R9", ($urandom % 4) != 0, ($urandom % 32) == 0, wc, op,
           1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);
    end
    idle("R9", 4);
    finish_run();
  end

endmodule